// File: doc/BRIEF.md
# Numeric Error Freeze Control

This block decides the fate of each floating-point instruction that is offered while an unmasked numeric exception may be pending. Each cycle it looks at a mode bit that selects native (internal) error reporting, an external ignore-error pin, a pending-exception flag, an instruction strobe carrying a 4-bit class code and an external interrupt. In the same clock it grants execution, raises an internal report, or starts a freeze.

Once frozen, the block refuses every instruction until an external interrupt is sampled. The frozen flag then clears on the next clock. A small set of control instructions bypasses the freeze. The ignore-error pin can also waive a pending exception, but only while native reporting is off. The floating-point datapath and exception dispatch sit outside this block.

Top module: `fpe_freeze_ctl`

## Requirements
- R1: The class code `insn_class` marks exempt control instructions with values 1 through 9. Value 0 and values 10 through 15 mark ordinary floating-point instructions.
- R2: With `native_rpt`=1 the level of `ign_err` has no effect. If an exception is pending, an ordinary instruction raises `rpt_int` in the same clock with `exec_go` low, and `frozen` stays low. An exempt instruction gets `exec_go`.
- R3: With `native_rpt`=0, `ign_err`=1 and an exception pending, every valid instruction of any class gets `exec_go` in the same clock, and no freeze follows.
- R4: With `native_rpt`=0, `ign_err`=0 and an exception pending, an exempt instruction gets `exec_go` in the same clock.
- R5: With `native_rpt`=0, `ign_err`=0 and an exception pending, an ordinary instruction gets neither `exec_go` nor `rpt_int`, and `frozen` is high from the next clock.
- R6: While `frozen` is high, `exec_go` and `rpt_int` stay low for every input pattern. `frozen` stays high on each clock edge where `ext_irq` is low, whatever the level of `ign_err`.
- R7: An `ext_irq` sampled high while frozen clears `frozen` in the next clock, after which instructions are accepted again.
- R8: With no exception pending and not frozen, every valid instruction gets `exec_go` in the same clock, whatever its class or the control inputs.
- R9: After reset `frozen` is low. With `insn_valid` low, `exec_go` and `rpt_int` are low and no freeze starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| native_rpt | input | 1 | 1 selects native internal error reporting |
| ign_err | input | 1 | External ignore-numeric-error request, active high |
| exc_pend | input | 1 | An unmasked numeric exception is pending |
| insn_valid | input | 1 | A floating-point instruction is offered this clock |
| insn_class | input | 4 | Instruction class code (see R1) |
| ext_irq | input | 1 | External interrupt, active high |
| exec_go | output | 1 | Instruction may execute this clock |
| rpt_int | output | 1 | Report the pending exception internally |
| frozen | output | 1 | Waiting for an external interrupt |

## Verification
The assertions assume that the inputs are stable and known at each rising edge and that reset is held for at least one edge. They also assume that `ext_irq` is meaningful even while no instruction is offered, because release depends only on the interrupt. The bench changes every input on the falling edge and holds it through the next rising edge, so each clocked property sees settled values. After reset it keeps a reference frozen flag of its own and compares the combinational outputs a short delay after each change.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_EXEC   = 2'd1,
    DEC_REPORT = 2'd2,
    DEC_FREEZE = 2'd3
  } fpe_dec_e;

  // Inclusive range test on a class code
  function automatic logic code_in_range(input logic [7:0] code,
                                         input logic [7:0] lo,
                                         input logic [7:0] hi);
    return (code >= lo) && (code <= hi);
  endfunction

  // Outcome for one offered instruction given the current mode inputs
  function automatic fpe_dec_e pick_outcome(input logic valid,
                                            input logic is_frozen,
                                            input logic exempt,
                                            input logic pend,
                                            input logic native,
                                            input logic ign);
    fpe_dec_e d;
    if (!valid || is_frozen)      d = DEC_IDLE;
    else if (!pend)               d = DEC_EXEC;
    else if (exempt)              d = DEC_EXEC;
    else if (native)              d = DEC_REPORT;
    else if (ign)                 d = DEC_EXEC;
    else                          d = DEC_FREEZE;
    return d;
  endfunction

endpackage

// File: rtl/fpe_class_decode.sv
module fpe_class_decode #(
  parameter int CLASS_W   = 4,
  parameter int EXEMPT_LO = 1,
  parameter int EXEMPT_HI = 9
) (
  input  logic [CLASS_W-1:0] insn_class,
  output logic               is_exempt
);
  import fpe_pkg::*;

  localparam int PAD_W = 8 - CLASS_W;
  localparam logic [7:0] LO8 = EXEMPT_LO[7:0];
  localparam logic [7:0] HI8 = EXEMPT_HI[7:0];

  logic [7:0] code8;

  generate
    if (PAD_W > 0) begin : g_pad
      assign code8 = {{PAD_W{1'b0}}, insn_class};
    end else begin : g_nopad
      assign code8 = insn_class[7:0];
    end
  endgenerate

  always_comb is_exempt = code_in_range(code8, LO8, HI8);

endmodule

// File: rtl/fpe_policy.sv
module fpe_policy (
  input  logic             insn_valid,
  input  logic             is_frozen,
  input  logic             is_exempt,
  input  logic             exc_pend,
  input  logic             native_rpt,
  input  logic             ign_err,
  output fpe_pkg::fpe_dec_e outcome
);
  import fpe_pkg::*;

  always_comb outcome = pick_outcome(insn_valid, is_frozen, is_exempt,
                                     exc_pend, native_rpt, ign_err);

endmodule

// File: rtl/fpe_freeze_fsm.sv
module fpe_freeze_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_evt,
  input  logic ext_irq,
  output logic frozen_q
);

  logic frozen_d;

  always_comb begin
    if (frozen_q) frozen_d = !ext_irq;
    else          frozen_d = freeze_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) frozen_q <= 1'b0;
    else        frozen_q <= frozen_d;
  end

  AST_FREEZE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> frozen_q); // R5
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !ext_irq) |=> frozen_q); // R6
  AST_FREEZE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && ext_irq) |=> !frozen_q); // R7
  AST_NO_SPURIOUS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen_q && !freeze_evt) |=> !frozen_q); // R9

endmodule

// File: rtl/fpe_freeze_ctl.sv
module fpe_freeze_ctl #(
  parameter int CLASS_W   = 4,
  parameter int EXEMPT_LO = 1,
  parameter int EXEMPT_HI = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               native_rpt,
  input  logic               ign_err,
  input  logic               exc_pend,
  input  logic               insn_valid,
  input  logic [CLASS_W-1:0] insn_class,
  input  logic               ext_irq,
  output logic               exec_go,
  output logic               rpt_int,
  output logic               frozen
);
  import fpe_pkg::*;

  // Named internal events
  logic     cls_exempt;
  fpe_dec_e outcome;
  logic     freeze_evt;
  logic     frozen_q;

  fpe_class_decode #(
    .CLASS_W  (CLASS_W),
    .EXEMPT_LO(EXEMPT_LO),
    .EXEMPT_HI(EXEMPT_HI)
  ) u_decode (
    .insn_class(insn_class),
    .is_exempt (cls_exempt)
  );

  fpe_policy u_policy (
    .insn_valid(insn_valid),
    .is_frozen (frozen_q),
    .is_exempt (cls_exempt),
    .exc_pend  (exc_pend),
    .native_rpt(native_rpt),
    .ign_err   (ign_err),
    .outcome   (outcome)
  );

  assign freeze_evt = (outcome == DEC_FREEZE);
  assign exec_go    = (outcome == DEC_EXEC);
  assign rpt_int    = (outcome == DEC_REPORT);
  assign frozen     = frozen_q;

  fpe_freeze_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze_evt(freeze_evt),
    .ext_irq   (ext_irq),
    .frozen_q  (frozen_q)
  );

  AST_FROZEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (!exec_go && !rpt_int)); // R6
  AST_NOPEND_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !exc_pend && !frozen) |-> exec_go); // R8
  AST_NATIVE_NEVER_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (native_rpt && !frozen) |=> !frozen); // R2
  AST_IGNORE_NEVER_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_err && !frozen) |=> !frozen); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> (!exec_go && !rpt_int)); // R9
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exec_go, rpt_int, freeze_evt})); // R5

endmodule

// File: tb/fpe_freeze_ctl_bench.sv
module fpe_freeze_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       native_rpt, ign_err, exc_pend, insn_valid, ext_irq;
  logic [3:0] insn_class;
  logic       exec_go, rpt_int, frozen;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  bit m_frozen = 0;

  always #10 clk = ~clk;

  fpe_freeze_ctl u_fpe_freeze_ctl (
    .clk(clk), .rst_n(rst_n), .native_rpt(native_rpt), .ign_err(ign_err),
    .exc_pend(exc_pend), .insn_valid(insn_valid), .insn_class(insn_class),
    .ext_irq(ext_irq), .exec_go(exec_go), .rpt_int(rpt_int), .frozen(frozen)
  );

  function automatic bit ref_exempt(input logic [3:0] c);
    return c inside {[4'd1:4'd9]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One cycle: drive on falling edge, check outputs, advance reference model
  task automatic step(input string req, input logic v, input logic [3:0] c,
                      input logic nat, input logic ign, input logic pend,
                      input logic irq);
    bit e_exec, e_rpt, e_frz;
    @(negedge clk);
    insn_valid = v; insn_class = c; native_rpt = nat;
    ign_err = ign; exc_pend = pend; ext_irq = irq;
    e_exec = 0; e_rpt = 0; e_frz = 0;
    if (v && !m_frozen) begin
      if (!pend || ref_exempt(c)) e_exec = 1;
      else if (nat)               e_rpt = 1;
      else if (ign)               e_exec = 1;
      else                        e_frz = 1;
    end
    #2;
    chk(req, "frozen", frozen, m_frozen);
    chk(req, "exec_go", exec_go, e_exec);
    chk(req, "rpt_int", rpt_int, e_rpt);
    @(posedge clk);
    m_frozen = m_frozen ? !irq : e_frz;
  endtask

  task automatic t_reset;
    rst_n = 0;
    native_rpt = 0; ign_err = 0; exc_pend = 0; insn_valid = 0;
    insn_class = 0; ext_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    m_frozen = 0;
    #2;
    chk("R9", "frozen after reset", frozen, 1'b0);
    chk("R9", "exec_go idle", exec_go, 1'b0);
    step("R9", 0, 4'd0, 0, 0, 1, 0);
    step("R9", 0, 4'd0, 0, 0, 1, 0);
  endtask

  task automatic t_no_pending;
    for (int c = 0; c < 16; c++) step("R8", 1, c[3:0], c[0], c[1], 0, 0);
  endtask

  task automatic t_native;
    for (int c = 0; c < 16; c++) step("R2", 1, c[3:0], 1, c[2], 1, 0);
    step("R2", 1, 4'd0, 1, 0, 1, 0);
    step("R2", 1, 4'd0, 1, 1, 1, 0);
    #1 chk("R2", "no freeze under native", frozen, 1'b0);
  endtask

  task automatic t_ignore;
    for (int c = 0; c < 16; c++) step("R3", 1, c[3:0], 0, 1, 1, 0);
    #1 chk("R3", "no freeze with ignore", frozen, 1'b0);
  endtask

  task automatic t_exempt;
    for (int c = 0; c < 16; c++) step("R1", 1, c[3:0], 1, 0, 1, 0);
    for (int c = 1; c <= 9; c++) step("R4", 1, c[3:0], 0, 0, 1, 0);
    #1 chk("R4", "exempt does not freeze", frozen, 1'b0);
  endtask

  task automatic t_freeze(input logic [3:0] c);
    step("R5", 1, c, 0, 0, 1, 0);
    #1 chk("R5", "frozen after ordinary", frozen, 1'b1);
    step("R6", 1, 4'd0, 0, 0, 0, 0);
    step("R6", 1, 4'd3, 1, 1, 1, 0);
    step("R6", 1, 4'd0, 0, 1, 1, 0);
    step("R6", 0, 4'd0, 0, 0, 0, 0);
    #1 chk("R6", "still frozen", frozen, 1'b1);
    step("R7", 0, 4'd0, 0, 0, 1, 1);
    #1 chk("R7", "released", frozen, 1'b0);
    step("R7", 1, 4'd5, 0, 0, 1, 0);
    step("R7", 1, 4'd0, 0, 0, 0, 0);
  endtask

  task automatic t_irq_not_frozen;
    step("R9", 0, 4'd0, 0, 0, 1, 1);
    step("R8", 1, 4'd0, 0, 0, 0, 1);
    #1 chk("R9", "irq alone no freeze", frozen, 1'b0);
    step("R5", 1, 4'd0, 0, 0, 1, 1);
    #1 chk("R5", "freeze despite irq at entry", frozen, 1'b1);
    step("R7", 1, 4'd0, 0, 0, 1, 1);
    step("R7", 1, 4'd0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_no_pending();
    t_native();
    t_ignore();
    t_exempt();
    t_freeze(4'd0);
    t_freeze(4'd12);
    t_irq_not_frozen();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule